// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the purely combinational datapath of a classic 8-bit accumulator machine. On each evaluation it takes an operation code, the accumulator-side operand, the memory-side operand, the current carry flag and the decimal-mode flag. It returns the new result byte and new sign (N), overflow (V), zero (Z) and carry (C) values. Along with these it returns a write enable for the accumulator and one write enable per flag, so that the surrounding status register keeps every flag the operation leaves alone.

The operations are add with carry, subtract with borrow (where carry acts as an inverted borrow), compare, the three bitwise logic operations, a bit test, two shifts and two rotates. When the decimal flag is set, add and subtract treat both bytes as two packed BCD digits. Compare uses the same subtractor but forces carry-in high and binary mode, and it writes no result, so it also serves to compare index registers when those are presented on the accumulator operand.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) gives result = (A + M + carry_in) mod 256. C is the binary carry out of bit 7, N is result bit 7, Z is set when the result is 0x00, and acc_we is 1.
- R2: Operation code 1 (subtract) gives result = (A - M - (1 - carry_in)) mod 256. C=1 means no borrow occurred and C=0 means a borrow occurred. N and Z follow the result, and acc_we is 1.
- R3: For codes 0 and 1, V is 1 exactly when the signed two's-complement value of A plus or minus M with carry falls outside -128..+127 (0x7F+0x01 with carry clear gives V=1; 0x81+0xFF gives V=0). In decimal mode V is still taken from this binary computation.
- R4: With dec_mode=1 and valid BCD operands, codes 0 and 1 produce the packed-BCD sum or difference modulo 100. C is the decimal carry out (for add) or the decimal no-borrow (for subtract), and N and Z are taken from the BCD result.
- R5: Operation code 2 (compare) sets C when A >= M unsigned, Z when A == M, and N from bit 7 of A - M. It ignores carry_in and dec_mode, holds acc_we at 0, returns A on result, and leaves we_v at 0.
- R6: Codes 3, 4 and 5 give A AND M, A OR M and A XOR M respectively. They enable only N and Z, with N = result bit 7 and Z = result zero.
- R7: Operation code 6 (bit test) sets Z when (A AND M) == 0, copies M bit 7 into N and M bit 6 into V, holds acc_we at 0, and returns A on result.
- R8: Code 7 shifts A left with 0 entering bit 0 and old bit 7 leaving into C. Code 8 shifts A right with 0 entering bit 7 and old bit 0 leaving into C. carry_in has no effect on either.
- R9: Code 9 rotates A left with carry_in entering bit 0 and old bit 7 leaving into C. Code 10 rotates A right with carry_in entering bit 7 and old bit 0 leaving into C.
- R10: The flag enables are {N,V,Z,C} for codes 0 and 1; {N,Z,C} for codes 2 and 7-10; {N,Z} for codes 3-5; and {N,V,Z} for code 6. Any flag output whose enable is 0 is driven 0.
- R11: Codes 11 to 15 are inert: all enables and acc_we are 0 and result equals A.
- R12: dec_mode changes only codes 0 and 1. Every other code gives identical outputs for dec_mode 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (encoding in R1-R11) |
| acc_a | input | 8 | Accumulator-side (register) operand |
| mem_m | input | 8 | Memory-side operand |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal-mode flag |
| result | output | 8 | Result byte (A when nothing is written) |
| acc_we | output | 1 | Result should be written to the register |
| flag_n | output | 1 | New sign flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| we_n | output | 1 | N is changed by this operation |
| we_v | output | 1 | V is changed by this operation |
| we_z | output | 1 | Z is changed by this operation |
| we_c | output | 1 | C is changed by this operation |

## Verification
The bench goes after carry and overflow at their edges: 0xFF+0x01 wrapping to zero, 0x7F+0x01 and 0x80-0x01 crossing the signed range, and 0x81+0xFF staying inside it. A design that computed V from unsigned carry, or that used carry rather than borrow polarity for subtract, fails these. Decimal vectors cross digit and byte boundaries (0x09+0x01, 0x58+0x46+1, 0x00-0x01) and catch a missing per-digit correction or a carry taken from the binary sum. Compare is driven with carry_in=0 and dec_mode=1 so that it shows whether either leaks in. Bit test and the inert codes confirm that the accumulator write stays off and that unaffected flags stay unenabled. A design that filled shifts with the carry or swapped rotate directions shows a wrong bit 0 or bit 7.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Shared operation encoding for the accumulator ALU. The numeric codes are
// part of the block's contract with the instruction decoder.
package alu8_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_BIT  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ROTL = 4'd9,
        OP_ROTR = 4'd10
    } alu_op_e;

    // Logic-unit function select
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module alu8_addsub
// Adder/subtractor with an optional packed-BCD correction path.
// Subtract is performed as A + ~M + cin, so cin acts as an inverted borrow.
// Assumes WIDTH is a multiple of 4 when the decimal path is used; decimal
// results are meaningful only for operands whose digits are all 0..9.
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opm,
    input  logic             cin,
    input  logic             sub,
    input  logic             dec,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int DIGITS = WIDTH / 4;

    logic [WIDTH-1:0] m_eff;
    logic [WIDTH:0]   bin_full;
    logic [WIDTH-1:0] dec_sum;
    logic             dec_cout;
    logic             ops_bcd;

    // Operand conditioning: invert memory operand for subtraction
    always_comb m_eff = sub ? ~opm : opm;

    // Binary sum with carry out in the extra top bit
    always_comb bin_full = {1'b0, opa} + {1'b0, m_eff} + {{WIDTH{1'b0}}, cin};

    // Signed overflow: like-signed inputs giving an opposite-signed result
    always_comb ovf = (opa[WIDTH-1] == m_eff[WIDTH-1]) &&
                      (bin_full[WIDTH-1] != opa[WIDTH-1]);

    // Decimal ripple: per-digit binary add followed by a +6 or -6 fix-up
    always_comb begin
        logic       cy;
        logic [4:0] raw;
        logic [3:0] fix;
        cy      = cin;
        dec_sum = '0;
        for (int g = 0; g < DIGITS; g++) begin
            raw = {1'b0, opa[4*g +: 4]} + {1'b0, m_eff[4*g +: 4]} + {4'd0, cy};
            if (sub) begin
                fix = raw[4] ? raw[3:0] : (raw[3:0] - 4'd6);
                cy  = raw[4];
            end else begin
                cy  = (raw > 5'd9);
                fix = cy ? (raw[3:0] + 4'd6) : raw[3:0];
            end
            dec_sum[4*g +: 4] = fix;
        end
        dec_cout = cy;
    end

    // Output selection between binary and decimal paths
    always_comb begin
        sum  = dec ? dec_sum  : bin_full[WIDTH-1:0];
        cout = dec ? dec_cout : bin_full[WIDTH];
    end

    // Operand digit validity, used only by the checks below
    always_comb begin
        ops_bcd = 1'b1;
        for (int g = 0; g < DIGITS; g++) begin
            if (opa[4*g +: 4] > 4'd9 || opm[4*g +: 4] > 4'd9) ops_bcd = 1'b0;
        end
    end

    // Decimal results stay inside the digit range for valid operands
    always_comb begin
        if (dec && ops_bcd) begin
            for (int g = 0; g < DIGITS; g++) begin
                AST_BCD_DIGIT_RANGE: assert (dec_sum[4*g +: 4] <= 4'd9); // R4
            end
        end
    end

endmodule

// File: rtl/alu8_logic.sv
// Module alu8_logic
// Bitwise AND / OR / XOR unit; AND also feeds the bit-test zero flag.
// Assumes the select is one of the three defined codes (others give AND).
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]         opa,
    input  logic [WIDTH-1:0]         opm,
    input  alu8_pkg::logic_sel_e     sel,
    output logic [WIDTH-1:0]         y
);
    import alu8_pkg::*;

    // Function select
    always_comb begin
        case (sel)
            LG_OR:   y = opa | opm;
            LG_XOR:  y = opa ^ opm;
            default: y = opa & opm;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
// Module alu8_shift
// One-position shifter/rotator. Direction picks left or right; rotate
// selects whether the vacated bit takes the carry or zero. The bit shifted
// out is returned as the new carry.
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic             cin,
    input  logic             left,
    input  logic             rotate,
    output logic [WIDTH-1:0] y,
    output logic             cout
);
    logic fill;

    // Vacated-bit value
    always_comb fill = rotate & cin;

    // Shift datapath
    always_comb begin
        if (left) begin
            y    = {opa[WIDTH-2:0], fill};
            cout = opa[WIDTH-1];
        end else begin
            y    = {fill, opa[WIDTH-1:1]};
            cout = opa[0];
        end
    end

endmodule

// File: rtl/alu8_core.sv
// Module alu8_core
// Top of the accumulator ALU: decodes the operation code, steers the
// operands into the adder, logic and shift units, and forms the result,
// the four flags and their write enables. Purely combinational; the
// caller owns the registers. Flags whose enable is low are driven 0.
module alu8_core #(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] acc_a,
    input  logic [WIDTH-1:0] mem_m,
    input  logic             carry_in,
    input  logic             dec_mode,
    output logic [WIDTH-1:0] result,
    output logic             acc_we,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c,
    output logic             we_n,
    output logic             we_v,
    output logic             we_z,
    output logic             we_c
);
    import alu8_pkg::*;

    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic             as_sub, as_cin, as_dec, as_cout, as_ovf;
    logic [WIDTH-1:0] as_sum;
    logic_sel_e       lg_sel;
    logic [WIDTH-1:0] lg_y;
    logic             sh_left, sh_rot, sh_cout;
    logic [WIDTH-1:0] sh_y;

    // Operation code typing
    always_comb op = alu_op_e'(op_sel);

    // Adder steering: compare is a forced binary subtract with no borrow in
    always_comb begin
        as_sub = (op == OP_SUB) || (op == OP_CMP);
        as_cin = (op == OP_CMP) ? 1'b1 : carry_in;
        as_dec = dec_mode && ((op == OP_ADD) || (op == OP_SUB));
    end

    // Logic unit steering
    always_comb begin
        case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    // Shifter steering
    always_comb begin
        sh_left = (op == OP_SHL)  || (op == OP_ROTL);
        sh_rot  = (op == OP_ROTL) || (op == OP_ROTR);
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .opa  (acc_a),
        .opm  (mem_m),
        .cin  (as_cin),
        .sub  (as_sub),
        .dec  (as_dec),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .opa (acc_a),
        .opm (mem_m),
        .sel (lg_sel),
        .y   (lg_y)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .opa    (acc_a),
        .cin    (carry_in),
        .left   (sh_left),
        .rotate (sh_rot),
        .y      (sh_y),
        .cout   (sh_cout)
    );

    // Result, flag and enable formation per operation
    always_comb begin
        result = acc_a;
        acc_we = 1'b0;
        flag_n = 1'b0; flag_v = 1'b0; flag_z = 1'b0; flag_c = 1'b0;
        we_n   = 1'b0; we_v   = 1'b0; we_z   = 1'b0; we_c   = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                result = as_sum;
                acc_we = 1'b1;
                flag_n = as_sum[MSB];
                flag_z = (as_sum == '0);
                flag_c = as_cout;
                flag_v = as_ovf;
                {we_n, we_v, we_z, we_c} = 4'b1111;
            end
            OP_CMP: begin
                flag_n = as_sum[MSB];
                flag_z = (as_sum == '0);
                flag_c = as_cout;
                {we_n, we_v, we_z, we_c} = 4'b1011;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result = lg_y;
                acc_we = 1'b1;
                flag_n = lg_y[MSB];
                flag_z = (lg_y == '0);
                {we_n, we_v, we_z, we_c} = 4'b1010;
            end
            OP_BIT: begin
                flag_n = mem_m[MSB];
                flag_v = mem_m[MSB-1];
                flag_z = (lg_y == '0);
                {we_n, we_v, we_z, we_c} = 4'b1110;
            end
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
                result = sh_y;
                acc_we = 1'b1;
                flag_n = sh_y[MSB];
                flag_z = (sh_y == '0);
                flag_c = sh_cout;
                {we_n, we_v, we_z, we_c} = 4'b1011;
            end
            default: ;
        endcase
    end

    // Checks on the assembled outputs against the operands
    always_comb begin
        AST_CMP_NO_WRITE: assert (!(op == OP_CMP) || (!acc_we && result == acc_a)); // R5
        AST_CMP_ORDER: assert (!(op == OP_CMP) || (flag_c == (acc_a >= mem_m))); // R5
        AST_BIT_COPIES: assert (!(op == OP_BIT) || (flag_n == mem_m[MSB] && flag_v == mem_m[MSB-1] && !acc_we)); // R7
        AST_V_ONLY_ARITH: assert (!we_v || op == OP_ADD || op == OP_SUB || op == OP_BIT); // R10
        AST_DISABLED_ZERO: assert ((we_n || !flag_n) && (we_v || !flag_v) && (we_z || !flag_z) && (we_c || !flag_c)); // R10
        AST_WRITE_FLAGS: assert (!acc_we || (flag_n == result[MSB] && flag_z == (result == '0))); // R6
        AST_ROTL_FILL: assert (!(op == OP_ROTL) || (result[0] == carry_in && flag_c == acc_a[MSB])); // R9
        AST_SHR_FILL: assert (!(op == OP_SHR) || (!result[MSB] && flag_c == acc_a[0])); // R8
        AST_INERT_CODES: assert (!(op_sel > 4'd10) || (!acc_we && !we_n && !we_v && !we_z && !we_c)); // R11
    end

endmodule

// File: tb/tb_alu8_core.sv
// Scoreboard bench for alu8_core: a driver task applies a stimulus on the
// falling edge and queues the expected outputs from an independent model;
// a monitor pops and compares on the next rising edge.
module tb_alu8_core;

    typedef struct packed {
        logic [7:0] res;
        logic       awe;
        logic       n, v, z, c;
        logic [3:0] en;   // {N,V,Z,C}
    } exp_t;

    logic       clk = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_a = '0, mem_m = '0;
    logic       carry_in = 1'b0, dec_mode = 1'b0;
    logic [7:0] result;
    logic       acc_we, flag_n, flag_v, flag_z, flag_c, we_n, we_v, we_z, we_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    alu8_core dut (
        .op_sel(op_sel), .acc_a(acc_a), .mem_m(mem_m),
        .carry_in(carry_in), .dec_mode(dec_mode),
        .result(result), .acc_we(acc_we),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .we_n(we_n), .we_v(we_v), .we_z(we_z), .we_c(we_c)
    );

    function automatic int bcd2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2bcd(int v);
        logic [3:0] hi, lo;
        hi = 4'((v / 10) % 10);
        lo = 4'(v % 10);
        return {hi, lo};
    endfunction

    // Independent reference written from the requirement list
    function automatic exp_t model(int op, logic [7:0] a, logic [7:0] m, logic ci, logic dm);
        exp_t e;
        int sa, sm, s, u;
        e = '0;
        e.res = a;
        sa = int'($signed(a));
        sm = int'($signed(m));
        case (op)
            0, 1: begin
                e.awe = 1'b1;
                e.en  = 4'b1111;
                if (op == 0) begin
                    s = sa + sm + int'(ci);
                    u = int'(a) + int'(m) + int'(ci);
                    e.res = 8'(u);
                    e.c = (u > 255);
                end else begin
                    s = sa - sm - (1 - int'(ci));
                    u = int'(a) - int'(m) - (1 - int'(ci));
                    e.res = 8'(u);
                    e.c = (u >= 0);
                end
                e.v = (s < -128) || (s > 127);
                if (dm) begin
                    if (op == 0) u = bcd2i(a) + bcd2i(m) + int'(ci);
                    else         u = bcd2i(a) - bcd2i(m) - (1 - int'(ci));
                    e.c = (op == 0) ? (u > 99) : (u >= 0);
                    e.res = i2bcd((u + 100) % 100);
                end
                e.n = e.res[7];
                e.z = (e.res == 8'h00);
            end
            2: begin
                u = int'(a) - int'(m);
                e.c = (a >= m);
                e.z = (a == m);
                e.n = logic'(8'(u) >> 7);
                e.en = 4'b1011;
            end
            3, 4, 5: begin
                e.awe = 1'b1;
                e.res = (op == 3) ? (a & m) : (op == 4) ? (a | m) : (a ^ m);
                e.n = e.res[7];
                e.z = (e.res == 8'h00);
                e.en = 4'b1010;
            end
            6: begin
                e.n = m[7];
                e.v = m[6];
                e.z = ((a & m) == 8'h00);
                e.en = 4'b1110;
            end
            7, 8, 9, 10: begin
                e.awe = 1'b1;
                e.en = 4'b1011;
                if (op == 7 || op == 9) begin
                    e.res = (a << 1) | ((op == 9) ? {7'd0, ci} : 8'd0);
                    e.c = a[7];
                end else begin
                    e.res = (a >> 1) | ((op == 10) ? {ci, 7'd0} : 8'd0);
                    e.c = a[0];
                end
                e.n = e.res[7];
                e.z = (e.res == 8'h00);
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(int op, logic [7:0] a, logic [7:0] m, logic ci, logic dm, string tag);
        @(negedge clk);
        op_sel = 4'(op); acc_a = a; mem_m = m; carry_in = ci; dec_mode = dm;
        exp_q.push_back(model(op, a, m, ci, dm));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the design against the oldest queued expectation
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                exp_t e, g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = '{res: result, awe: acc_we, n: flag_n, v: flag_v, z: flag_z, c: flag_c,
                      en: {we_n, we_v, we_z, we_c}};
                checks++;
                if (g !== e) begin
                    fails++;
                    $display("FAIL %s: got res=%h we=%b NVZC=%b%b%b%b en=%b, expected res=%h we=%b NVZC=%b%b%b%b en=%b",
                             t, g.res, g.awe, g.n, g.v, g.z, g.c, g.en,
                             e.res, e.awe, e.n, e.v, e.z, e.c, e.en);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 binary add
        drive(0, 8'h12, 8'h34, 0, 0, "R1 add");
        drive(0, 8'hFF, 8'h01, 0, 0, "R1 add wrap zero");
        drive(0, 8'h10, 8'h20, 1, 0, "R1 add carry in");
        // R2 binary subtract, inverted borrow
        drive(1, 8'h50, 8'h20, 1, 0, "R2 sub no borrow");
        drive(1, 8'h10, 8'h20, 1, 0, "R2 sub borrow");
        drive(1, 8'h05, 8'h05, 0, 0, "R2 sub borrow in");
        // R3 signed overflow
        drive(0, 8'h7F, 8'h01, 0, 0, "R3 add overflow");
        drive(0, 8'h81, 8'hFF, 0, 0, "R3 add no overflow");
        drive(1, 8'h80, 8'h01, 1, 0, "R3 sub overflow");
        drive(0, 8'h79, 8'h10, 0, 1, "R3 decimal V from binary");
        // R4 packed BCD
        drive(0, 8'h58, 8'h46, 1, 1, "R4 bcd add carry");
        drive(0, 8'h09, 8'h01, 0, 1, "R4 bcd digit carry");
        drive(0, 8'h99, 8'h00, 1, 1, "R4 bcd add to zero");
        drive(1, 8'h00, 8'h01, 1, 1, "R4 bcd sub borrow");
        drive(1, 8'h46, 8'h12, 1, 1, "R4 bcd sub");
        drive(1, 8'h40, 8'h05, 0, 1, "R4 bcd sub borrow in");
        // R5 compare
        drive(2, 8'h40, 8'h40, 0, 0, "R5 cmp equal");
        drive(2, 8'h10, 8'h20, 1, 0, "R5 cmp less");
        drive(2, 8'h80, 8'h01, 0, 1, "R5 cmp ignores carry and decimal");
        // R6 logic
        drive(3, 8'hF0, 8'h3C, 1, 0, "R6 and");
        drive(4, 8'h00, 8'h00, 0, 0, "R6 or zero");
        drive(5, 8'hFF, 8'h7F, 0, 0, "R6 xor");
        // R7 bit test
        drive(6, 8'h0F, 8'hC0, 0, 0, "R7 bit zero N V");
        drive(6, 8'h01, 8'h41, 1, 0, "R7 bit nonzero V");
        // R8 shifts
        drive(7, 8'h81, 8'h00, 0, 0, "R8 shl");
        drive(8, 8'h01, 8'h00, 1, 0, "R8 shr ignores carry");
        drive(7, 8'h40, 8'h00, 1, 0, "R8 shl ignores carry");
        // R9 rotates
        drive(9, 8'h80, 8'h00, 1, 0, "R9 rotl");
        drive(10, 8'h01, 8'h00, 1, 0, "R9 rotr");
        drive(10, 8'h02, 8'h00, 0, 0, "R9 rotr no carry");
        // R10 enables on each family, R11 inert codes
        drive(11, 8'hA5, 8'h5A, 1, 0, "R11 code 11");
        drive(15, 8'h00, 8'hFF, 1, 1, "R11 code 15");
        drive(5, 8'hAA, 8'h55, 1, 0, "R10 logic enables");
        // R12 decimal flag has no effect outside add/subtract
        drive(3, 8'h99, 8'h0F, 0, 1, "R12 and with decimal");
        drive(9, 8'h99, 8'h00, 1, 1, "R12 rotl with decimal");
        drive(6, 8'h99, 8'h40, 0, 1, "R12 bit with decimal");
        // Sweep of binary add and subtract
        for (int i = 0; i < 48; i++) begin
            logic [7:0] a, m;
            a = 8'(i * 37 + 5);
            m = 8'(i * 91 + 17);
            drive(i % 2, a, m, logic'(i[2]), 0, (i % 2 == 0) ? "R1 sweep" : "R2 sweep");
        end
        // Sweep of decimal add and subtract over valid digits
        for (int i = 0; i < 24; i++) begin
            drive(i % 2, i2bcd((i * 37) % 100), i2bcd((i * 53 + 11) % 100), logic'(i[1]), 1, "R4 sweep");
        end
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule